// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block produces the serial clock for an I2C controller from the core clock. The high and low times are set in whole core-clock ticks by one 16-bit divisor register. The high-time field also sets how long SCL stays high after the data line falls for a START condition.

A transfer engine drives the block with three inputs: a run enable, a START request and a STOP request. The block returns the SCL level together with one-cycle strobes:

- a START strobe in the cycle the data line should fall;
- a mid-low strobe, where the data line may change;
- a rise strobe on each SCL rising edge, for sampling;
- a done strobe once the clock has settled high after a STOP.

While the line is released high but still sensed low, because a target is holding it, the high-phase count pauses.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset the divisor register holds 0x1F1F, SCL is high, and every strobe is low. These defaults give a 30-tick START hold, 32-tick low phases and 33-tick high phases.
- R2: A write with `div_we` high loads `div_wdata`. Bits 15:8 are the high-time field H and bits 7:0 are the low-time field L.
- R3: Each SCL low phase lasts L+1 core-clock cycles.
- R4: Each SCL high phase between two low phases lasts H+2 core-clock cycles when the line is not held low.
- R5: A `start_req` sampled while idle and `run` is high raises `start_edge` for one cycle, in the cycle after it is sampled. SCL first falls H−1 cycles after that, or 1 cycle after it when H is below 2.
- R6: `low_mid` pulses once per low phase, at offset L − floor(L/2) cycles from the cycle in which SCL fell. With L = 0 this is the falling cycle itself.
- R7: `scl_rise` is high for exactly the first cycle of each SCL high level that follows a low phase.
- R8: During a high phase, every cycle in which `scl_sense` is low while SCL is driven high adds one cycle to that phase.
- R9: A `stop_req` taken while a transfer is active makes the next low phase end in a final high phase of H+2 cycles. `done` then pulses for one cycle and SCL stays high in idle.
- R10: A divisor write takes effect at the start of the next phase. The phase in progress, including its midpoint, keeps the old value.
- R11: `run` low returns the block to idle with SCL high from the next cycle. A `start_req` seen while `run` is low produces no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable; low forces idle |
| start_req | input | 1 | Request a START condition and clocking |
| stop_req | input | 1 | Request a STOP after the current or next low phase |
| div_we | input | 1 | Divisor register write strobe |
| div_wdata | input | 16 | Divisor value: high field 15:8, low field 7:0 |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_o | output | 1 | Driven SCL level (1 = released) |
| start_edge | output | 1 | One-cycle strobe: data line should fall now |
| low_mid | output | 1 | One-cycle strobe at the middle of a low phase |
| scl_rise | output | 1 | One-cycle strobe on each SCL rising edge |
| done | output | 1 | One-cycle strobe after the STOP high phase |

## Verification
Timing is counted from the edge that samples a request. When `start_req` is sampled at edge P, `start_edge` is visible in cycle P, SCL falls at P+H−1, `low_mid` follows L−floor(L/2) cycles into the low phase, and the rise and its strobe come L+1 cycles after the fall. For every transfer the bench computes this whole timeline from the requirements and queues each expected event with its cycle number. A monitor compares the queued events against what the outputs show, sampling half a cycle after each edge, so any early, late, missing or extra event fails. Divisor writes, the start of a stretch and the stop request are driven at cycle numbers taken from the same timeline, so each one lands in a known phase.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    localparam int FIELD_W = 8;
    localparam int DIV_W   = 2 * FIELD_W;
    localparam int CNT_W   = FIELD_W + 1;

    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } div_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LOW,
        PH_HIGH,
        PH_STOP
    } phase_e;

    // counter preload for the START hold: hi-1 cycles, never below one
    function automatic logic [CNT_W-1:0] hold_ticks(logic [FIELD_W-1:0] hi);
        return (hi >= FIELD_W'(2)) ? (CNT_W'(hi) - CNT_W'(2)) : '0;
    endfunction

    // counter preload for a high phase: hi+2 cycles
    function automatic logic [CNT_W-1:0] high_ticks(logic [FIELD_W-1:0] hi);
        return CNT_W'(hi) + CNT_W'(1);
    endfunction

    // counter preload for a low phase: lo+1 cycles
    function automatic logic [CNT_W-1:0] low_ticks(logic [FIELD_W-1:0] lo);
        return CNT_W'(lo);
    endfunction

endpackage

// File: rtl/sclgen_divreg.sv
module sclgen_divreg
    import sclgen_pkg::*;
#(
    parameter logic [DIV_W-1:0] RST_VAL = 16'h1F1F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [DIV_W-1:0] wdata,
    output div_t             q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= div_t'(RST_VAL);
        else if (we) q <= div_t'(wdata);
    end

    // R10
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/sclgen_tick_ctr.sv
module sclgen_tick_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         zero
);

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (ld)           cnt <= ld_val;
        else if (en && !zero)  cnt <= cnt - W'(1);
    end

    // R3
    ctr_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (zero && !ld) |=> zero);

endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
    import sclgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             scl_sense,
    input  div_t             div,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_zero,
    output logic             ld,
    output logic [CNT_W-1:0] ld_val,
    output logic             cnt_en,
    output logic             scl_o,
    output logic             start_edge,
    output logic             low_mid,
    output logic             scl_rise,
    output logic             done
);

    phase_e             state, nxt;
    logic               stop_pend;
    logic [FIELD_W-1:0] mid_r;
    logic               stretch, fin;

    assign stretch = ((state == PH_HIGH) || (state == PH_STOP)) && !scl_sense;
    assign fin     = cnt_zero && !stretch;
    assign cnt_en  = !stretch;

    always_comb begin
        nxt    = state;
        ld     = 1'b0;
        ld_val = '0;
        unique case (state)
            PH_IDLE: if (start_req) begin
                nxt = PH_HOLD; ld = 1'b1; ld_val = hold_ticks(div.hi);
            end
            PH_HOLD: if (fin) begin
                nxt = PH_LOW; ld = 1'b1; ld_val = low_ticks(div.lo);
            end
            PH_LOW: if (fin) begin
                nxt = stop_pend ? PH_STOP : PH_HIGH;
                ld = 1'b1; ld_val = high_ticks(div.hi);
            end
            PH_HIGH: if (fin) begin
                nxt = PH_LOW; ld = 1'b1; ld_val = low_ticks(div.lo);
            end
            PH_STOP: if (fin) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
        if (!run) begin
            nxt = PH_IDLE;
            ld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PH_IDLE;
            stop_pend  <= 1'b0;
            mid_r      <= '0;
            start_edge <= 1'b0;
            scl_rise   <= 1'b0;
            done       <= 1'b0;
        end else begin
            state <= nxt;
            if (!run || nxt == PH_IDLE || nxt == PH_STOP)
                stop_pend <= 1'b0;
            else if (stop_req && state != PH_IDLE)
                stop_pend <= 1'b1;
            if (ld && nxt == PH_LOW)
                mid_r <= div.lo >> 1;
            start_edge <= (state == PH_IDLE) && (nxt == PH_HOLD);
            scl_rise   <= (state == PH_LOW) && (nxt != PH_LOW);
            done       <= (state == PH_STOP) && fin && run;
        end
    end

    assign scl_o   = (state != PH_LOW);
    assign low_mid = (state == PH_LOW) && (cnt == {1'b0, mid_r});

    // R7
    rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
        scl_rise |-> (scl_o && !$past(scl_o)));

    // R6
    mid_in_low_chk: assert property (@(posedge clk) disable iff (rst)
        low_mid |-> !scl_o);

    // R9
    done_high_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (scl_o && !low_mid));

    // R11
    run_off_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (scl_o && !low_mid && !start_edge));

    // R8
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_HIGH && !scl_sense && run) |=> $stable(cnt));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import sclgen_pkg::*;
#(
    parameter logic [15:0] DIV_RST = 16'h1F1F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        start_req,
    input  logic        stop_req,
    input  logic        div_we,
    input  logic [15:0] div_wdata,
    input  logic        scl_sense,
    output logic        scl_o,
    output logic        start_edge,
    output logic        low_mid,
    output logic        scl_rise,
    output logic        done
);

    div_t             div;
    logic             ld, cnt_en, cnt_zero;
    logic [CNT_W-1:0] ld_val, cnt;

    sclgen_divreg #(.RST_VAL(DIV_RST)) u_div (
        .clk(clk), .rst(rst), .we(div_we), .wdata(div_wdata), .q(div)
    );

    sclgen_tick_ctr #(.W(CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val), .en(cnt_en),
        .cnt(cnt), .zero(cnt_zero)
    );

    sclgen_ctrl u_ctrl (
        .clk(clk), .rst(rst), .run(run), .start_req(start_req),
        .stop_req(stop_req), .scl_sense(scl_sense), .div(div),
        .cnt(cnt), .cnt_zero(cnt_zero), .ld(ld), .ld_val(ld_val),
        .cnt_en(cnt_en), .scl_o(scl_o), .start_edge(start_edge),
        .low_mid(low_mid), .scl_rise(scl_rise), .done(done)
    );

endmodule

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;

    typedef enum int {EV_START, EV_FALL, EV_MID, EV_RISE, EV_DONE} ev_e;
    typedef struct {
        ev_e   kind;
        int    cyc;
        string req;
    } ev_t;

    logic clk = 1'b0, rst = 1'b1, run = 1'b1, start_req = 1'b0, stop_req = 1'b0;
    logic div_we = 1'b0, force_low = 1'b0;
    logic [15:0] div_wdata = '0;
    logic scl_o, start_edge, low_mid, scl_rise, done, scl_sense;

    int cyc = 0, tests = 0, fails = 0, n_ev = 0;
    int cur_h = 'h1F, cur_l = 'h1F;
    bit finished = 1'b0, prev_scl = 1'b1;
    ev_t exp_q[$];

    assign scl_sense = scl_o & ~force_low;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_scl_timer u_dut (
        .clk(clk), .rst(rst), .run(run), .start_req(start_req),
        .stop_req(stop_req), .div_we(div_we), .div_wdata(div_wdata),
        .scl_sense(scl_sense), .scl_o(scl_o), .start_edge(start_edge),
        .low_mid(low_mid), .scl_rise(scl_rise), .done(done)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic void push(input ev_e k, input int c, input string req);
        ev_t e;
        e.kind = k; e.cyc = c; e.req = req;
        exp_q.push_back(e);
    endfunction

    function automatic string kind_req(input ev_e k);
        case (k)
            EV_START: return "R5";
            EV_FALL:  return "R3";
            EV_MID:   return "R6";
            EV_RISE:  return "R7";
            default:  return "R9";
        endcase
    endfunction

    task automatic chk_ev(input ev_e k);
        ev_t e;
        n_ev++;
        if (exp_q.size() == 0) begin
            check_eq(kind_req(k), int'(k), -1);
        end else begin
            e = exp_q.pop_front();
            check_eq(e.req, int'(k), int'(e.kind));
            check_eq(e.req, cyc, e.cyc);
        end
    endtask

    // monitor: compares observed events against the scoreboard queue
    always @(negedge clk) begin
        if (!rst) begin
            if (start_edge)           chk_ev(EV_START);
            if (prev_scl && !scl_o)   chk_ev(EV_FALL);
            if (low_mid)              chk_ev(EV_MID);
            if (scl_rise)             chk_ev(EV_RISE);
            if (done)                 chk_ev(EV_DONE);
            if ((!prev_scl && scl_o) || scl_rise)
                check_eq("R7", int'(scl_rise), int'(!prev_scl && scl_o));
            prev_scl = scl_o;
        end
    end

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wr_div(input logic [15:0] v);
        div_we = 1'b1; div_wdata = v;
        @(negedge clk);
        div_we = 1'b0;
        cur_h = int'(v[15:8]); cur_l = int'(v[7:0]);
    endtask

    // driver: queues the expected timeline, then drives the stimulus
    task automatic txn(input bit do_wr, input logic [15:0] wv, input int nhi,
                       input int st_ph, input int st_len);
        int h0, l0, h1, l1, hh, ll, p, f, f0, fl, r, rs, dn;
        string fr, rr;
        h0 = cur_h; l0 = cur_l;
        h1 = do_wr ? int'(wv[15:8]) : h0;
        l1 = do_wr ? int'(wv[7:0])  : l0;
        hh = h1;
        p = cyc + 1;
        rs = 0; dn = 0; fl = 0;
        push(EV_START, p, "R5");
        f = p + ((h0 >= 2) ? h0 - 1 : 1);
        f0 = f;
        for (int i = 0; i <= nhi; i++) begin
            ll = (i == 0) ? l0 : l1;
            if (i == 0)                              fr = "R5";
            else if (do_wr)                          fr = "R10";
            else if (i - 1 == st_ph && st_len > 0)   fr = "R8";
            else                                     fr = "R4";
            rr = (do_wr && i == 0) ? "R10" : "R3";
            if (i == nhi) fl = f;
            push(EV_FALL, f, fr);
            push(EV_MID, f + ll - (ll >> 1), "R6");
            r = f + ll + 1;
            push(EV_RISE, r, rr);
            if (i == st_ph) rs = r;
            if (i < nhi) f = r + hh + 2 + ((i == st_ph) ? st_len : 0);
            else         dn = r + hh + 2;
        end
        push(EV_DONE, dn, "R9");

        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        if (do_wr) begin
            wait_cyc(f0);
            wr_div(wv);
        end
        if (st_len > 0) begin
            wait_cyc(rs + 1);
            force_low = 1'b1;
            wait_cyc(rs + 1 + st_len);
            force_low = 1'b0;
        end
        wait_cyc(fl - 1);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        wait_cyc(dn + 2);
        check_eq("R9", exp_q.size(), 0);
        check_eq("R9", int'(scl_o), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int r, p, f, base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        check_eq("R1", int'(scl_o), 1);
        check_eq("R1", int'(start_edge | low_mid | scl_rise | done), 0);
        repeat (5) @(negedge clk);

        // R1: default divisor timing (hold 30, low 32, high 33)
        txn(1'b0, 16'h0, 1, -1, 0);
        // R2: field positions with distinct high and low values
        wr_div(16'h0305);
        txn(1'b0, 16'h0, 3, -1, 0);
        // R5 / R6 corner: zero fields
        wr_div(16'h0000);
        txn(1'b0, 16'h0, 2, -1, 0);
        // R10: write during the first low phase
        wr_div(16'h0305);
        txn(1'b1, 16'h0602, 2, -1, 0);
        // R8: stretch of four cycles in the first high phase
        txn(1'b0, 16'h0, 2, 0, 4);

        // R11: start ignored while run is low
        run = 1'b0;
        @(negedge clk);
        base = n_ev;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (40) @(negedge clk);
        check_eq("R11", n_ev - base, 0);
        check_eq("R11", int'(scl_o), 1);
        run = 1'b1;
        @(negedge clk);

        // R11: run drop during a high phase aborts to idle
        p = cyc + 1;
        f = p + cur_h - 1;
        r = f + cur_l + 1;
        push(EV_START, p, "R5");
        push(EV_FALL, f, "R5");
        push(EV_MID, f + cur_l - (cur_l >> 1), "R6");
        push(EV_RISE, r, "R3");
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        wait_cyc(r + 1);
        run = 1'b0;
        base = n_ev;
        repeat (30) @(negedge clk);
        check_eq("R11", exp_q.size(), 0);
        check_eq("R11", n_ev - base, 0);
        check_eq("R11", int'(scl_o), 1);
        run = 1'b1;
        repeat (3) @(negedge clk);

        // restart after the abort still works
        txn(1'b0, 16'h0, 1, -1, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule